// File: doc/BRIEF.md
# Processor Power-Down Mode Controller

This controller decides which low-power state a processor is in and drives the control levels for each clock and power domain. Four entry paths exist. A sleep-instruction strobe enters either light sleep or software standby, depending on a standby-select bit. Per-module stop bits gate individual peripherals. An active-low hardware-standby pin forces the deepest state. Each path has its own exit rule and its own setting for the CPU clock, the clock generator, the peripheral clocks and the external-memory refresh mode.

Every output is registered and is updated on the clock edge that samples the inputs. The outputs are level controls for the clock generator, the peripherals, the memory controller, the real-time clock and the timer. Those blocks are outside this controller. Register and memory contents are never cleared on entry to a low-power state. Only a reset does that.

Top module: `pwrdn_ctrl`

## Requirements
- R1: While `por_n` is sampled low, the next edge sets `cpu_clk_en`, `cpg_en`, every `mod_clk_en` bit, `rtc_run_en` and `tmu_run_en` to 1, and sets `mem_self_ref` and `sci_pin_rst` to 0.
- R2: A `sleep_stb` pulse in the running state with `stby_sel`=0 enters sleep on the same edge: `cpu_clk_en`=0, `cpg_en`=1, `mem_self_ref`=0, and peripherals stay enabled according to their stop bits.
- R3: A `sleep_stb` pulse in the running state with `stby_sel`=1 enters software standby on the same edge: `cpu_clk_en`=0, `cpg_en`=0, all `mod_clk_en`=0, `mem_self_ref`=1.
- R4: In sleep, `irq`=1 or `mrst_n`=0 returns to the running state on the next edge, with `cpu_clk_en`=1.
- R5: In software standby, `irq`=1 or `mrst_n`=0 first gives one cycle with `cpg_en`=1, `cpu_clk_en`=0 and `mem_self_ref`=1. The edge after that gives `cpu_clk_en`=1 and `mem_self_ref`=0.
- R6: In the running state and in sleep, `mod_clk_en[i]` equals the inverse of `mod_stop[i]`, and the CPU is unaffected. When `mrst_n` is sampled low and the result is the running state, all `mod_clk_en` bits are 1 regardless of the stop bits.
- R7: `sci_pin_rst` is 1 exactly when the serial module (index `SCI_IDX`=1) is stopped by its own stop bit in the running state or in sleep. The timer (index `TMU_IDX`=0) has no such output, so its pin holds its level.
- R8: `hwstby_n`=0 sampled at any edge outside reset enters hardware standby from any state. In hardware standby `cpu_clk_en`=0, `cpg_en`=0, all `mod_clk_en`=0, `mem_self_ref`=1 and `tmu_run_en`=0.
- R9: Hardware standby is left only through `por_n`=0. `irq`, `mrst_n`=0 and a return of `hwstby_n` to 1 have no effect on the outputs.
- R10: `rtc_run_en` follows `rtc_start` in every state. In software standby, and in the cycle that follows it, `tmu_run_en` = `rtc_start` AND `tmu_src_rtc`.
- R11: `sleep_stb` has no effect outside the running state, and `irq` has no effect in the running state.
- R12: `cpu_clk_en`=1 never occurs with `cpg_en`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| por_n | input | 1 | Power-on reset, synchronous, active low |
| mrst_n | input | 1 | Manual reset request, active low |
| sleep_stb | input | 1 | One-cycle strobe from the sleep instruction |
| stby_sel | input | 1 | 1 selects software standby, 0 selects sleep |
| mod_stop | input | NMOD | Per-module stop bits, 1 halts the module |
| hwstby_n | input | 1 | Hardware-standby pin, active low |
| irq | input | 1 | Wake-up interrupt request |
| rtc_start | input | 1 | Real-time-clock start bit |
| tmu_src_rtc | input | 1 | Timer counts from the real-time-clock output |
| cpu_clk_en | output | 1 | CPU clock enable |
| cpg_en | output | 1 | Clock-generator enable |
| mod_clk_en | output | NMOD | Per-peripheral clock enables |
| mem_self_ref | output | 1 | 1 selects memory self-refresh, 0 selects auto-refresh |
| rtc_run_en | output | 1 | Real-time-clock run enable |
| tmu_run_en | output | 1 | Timer run enable |
| sci_pin_rst | output | 1 | Returns the serial pin to its reset state |

## Verification
The hardest case to bring about is the two-step exit from software standby. The clock generator must come up one full cycle before the CPU, and that can only be seen across two consecutive edges after the wake-up request. The stimulus enters standby with a strobe, changes the timer and clock source bits while there, then raises `irq` and samples the outputs after each of the next two edges. Hardware standby is entered from sleep and from standby. In that state the bench applies interrupt, manual reset and pin release before any power-on reset, and checks after each one that nothing moved.

// File: rtl/pwrdn_pkg.sv
// Shared types for the power-down controller.
package pwrdn_pkg;

    // Controller states; PD_WAKE is the one-cycle clock-generator restart step.
    typedef enum logic [2:0] {
        PD_RUN   = 3'd0,
        PD_SLEEP = 3'd1,
        PD_SSTBY = 3'd2,
        PD_WAKE  = 3'd3,
        PD_HSTBY = 3'd4
    } pd_state_t;

    // Domain control levels implied by a state.
    typedef struct packed {
        logic cpu_en;
        logic cpg_en;
        logic self_ref;
        logic periph_run;
        logic tmu_by_rtc;
        logic tmu_off;
    } pd_ctl_t;

endpackage

// File: rtl/pwrdn_fsm.sv
// Next-state logic of the power-down controller.
// Assumes: por_n is handled by the caller's state register; the hardware
// standby pin outranks every other request; the sleep strobe lasts one cycle.
module pwrdn_fsm
    import pwrdn_pkg::*;
(
    input  pd_state_t state_q,
    input  logic      mrst_n,
    input  logic      hwstby_n,
    input  logic      sleep_stb,
    input  logic      stby_sel,
    input  logic      irq,
    output pd_state_t state_d
);

    // Pick the next state from current state and wake/entry requests.
    always_comb begin
        state_d = state_q;
        if (!hwstby_n) begin
            state_d = PD_HSTBY;
        end else begin
            case (state_q)
                PD_RUN: begin
                    if (mrst_n && sleep_stb)
                        state_d = stby_sel ? PD_SSTBY : PD_SLEEP;
                end
                PD_SLEEP: begin
                    if (!mrst_n || irq)
                        state_d = PD_RUN;
                end
                PD_SSTBY: begin
                    if (!mrst_n || irq)
                        state_d = PD_WAKE;
                end
                PD_WAKE:  state_d = PD_RUN;
                PD_HSTBY: state_d = PD_HSTBY;
                default:  state_d = PD_RUN;
            endcase
        end
    end

endmodule

// File: rtl/pwrdn_decode.sv
// Maps a controller state onto the domain control levels.
// Assumes: purely combinational; the caller registers the result.
module pwrdn_decode
    import pwrdn_pkg::*;
(
    input  pd_state_t state,
    output pd_ctl_t   ctl
);

    // Per-state table of clock, refresh and timer rules.
    always_comb begin
        ctl = '0;
        case (state)
            PD_RUN:   ctl = '{cpu_en: 1'b1, cpg_en: 1'b1, self_ref: 1'b0,
                              periph_run: 1'b1, tmu_by_rtc: 1'b0, tmu_off: 1'b0};
            PD_SLEEP: ctl = '{cpu_en: 1'b0, cpg_en: 1'b1, self_ref: 1'b0,
                              periph_run: 1'b1, tmu_by_rtc: 1'b0, tmu_off: 1'b0};
            PD_SSTBY: ctl = '{cpu_en: 1'b0, cpg_en: 1'b0, self_ref: 1'b1,
                              periph_run: 1'b0, tmu_by_rtc: 1'b1, tmu_off: 1'b0};
            PD_WAKE:  ctl = '{cpu_en: 1'b0, cpg_en: 1'b1, self_ref: 1'b1,
                              periph_run: 1'b0, tmu_by_rtc: 1'b1, tmu_off: 1'b0};
            PD_HSTBY: ctl = '{cpu_en: 1'b0, cpg_en: 1'b0, self_ref: 1'b1,
                              periph_run: 1'b0, tmu_by_rtc: 1'b0, tmu_off: 1'b1};
            default:  ctl = '{cpu_en: 1'b1, cpg_en: 1'b1, self_ref: 1'b0,
                              periph_run: 1'b1, tmu_by_rtc: 1'b0, tmu_off: 1'b0};
        endcase
    end

endmodule

// File: rtl/pwrdn_modgate.sv
// Per-peripheral clock enable generation.
// Assumes: force_all comes from a manual reset that lands in the running state.
module pwrdn_modgate #(
    parameter int NMOD = 4
) (
    input  logic            periph_run,
    input  logic            force_all,
    input  logic [NMOD-1:0] mod_stop,
    output logic [NMOD-1:0] en_d
);

    for (genvar i = 0; i < NMOD; i++) begin : g_mod
        // One enable per module: reset forces it on, else the stop bit gates it.
        always_comb en_d[i] = force_all | (periph_run & ~mod_stop[i]);
    end

endmodule

// File: rtl/pwrdn_ctrl.sv
// Power-down mode controller top level.
// Holds the state register and registers every domain control output.
// Assumes: por_n is a synchronous active-low reset; TMU_IDX and SCI_IDX name
// the timer and serial modules among the NMOD stop bits.
module pwrdn_ctrl
    import pwrdn_pkg::*;
#(
    parameter int NMOD    = 4,
    parameter int TMU_IDX = 0,
    parameter int SCI_IDX = 1
) (
    input  logic            clk,
    input  logic            por_n,
    input  logic            mrst_n,
    input  logic            sleep_stb,
    input  logic            stby_sel,
    input  logic [NMOD-1:0] mod_stop,
    input  logic            hwstby_n,
    input  logic            irq,
    input  logic            rtc_start,
    input  logic            tmu_src_rtc,
    output logic            cpu_clk_en,
    output logic            cpg_en,
    output logic [NMOD-1:0] mod_clk_en,
    output logic            mem_self_ref,
    output logic            rtc_run_en,
    output logic            tmu_run_en,
    output logic            sci_pin_rst
);

    pd_state_t       state_q;
    pd_state_t       state_d;
    pd_ctl_t         ctl_d;
    logic            force_all;
    logic [NMOD-1:0] mod_en_d;
    logic            tmu_d;
    logic            sci_rst_d;

    pwrdn_fsm u_fsm (
        .state_q   (state_q),
        .mrst_n    (mrst_n),
        .hwstby_n  (hwstby_n),
        .sleep_stb (sleep_stb),
        .stby_sel  (stby_sel),
        .irq       (irq),
        .state_d   (state_d)
    );

    pwrdn_decode u_dec (
        .state (state_d),
        .ctl   (ctl_d)
    );

    // A manual reset restarts every module only when it lands in the running state.
    always_comb force_all = !mrst_n && (state_d == PD_RUN);

    pwrdn_modgate #(.NMOD(NMOD)) u_gate (
        .periph_run (ctl_d.periph_run),
        .force_all  (force_all),
        .mod_stop   (mod_stop),
        .en_d       (mod_en_d)
    );

    // Timer rule: off in hardware standby, clock-source rule in software standby.
    always_comb begin
        if (ctl_d.tmu_off)
            tmu_d = 1'b0;
        else if (ctl_d.tmu_by_rtc)
            tmu_d = rtc_start & tmu_src_rtc;
        else
            tmu_d = mod_en_d[TMU_IDX];
    end

    // Serial pin is returned to reset only while its own stop bit halts it.
    always_comb sci_rst_d = ctl_d.periph_run & ~force_all & mod_stop[SCI_IDX];

    // State register and registered outputs.
    always_ff @(posedge clk) begin
        if (!por_n) begin
            state_q      <= PD_RUN;
            cpu_clk_en   <= 1'b1;
            cpg_en       <= 1'b1;
            mod_clk_en   <= '1;
            mem_self_ref <= 1'b0;
            rtc_run_en   <= 1'b1;
            tmu_run_en   <= 1'b1;
            sci_pin_rst  <= 1'b0;
        end else begin
            state_q      <= state_d;
            cpu_clk_en   <= ctl_d.cpu_en;
            cpg_en       <= ctl_d.cpg_en;
            mod_clk_en   <= mod_en_d;
            mem_self_ref <= ctl_d.self_ref;
            rtc_run_en   <= rtc_start;
            tmu_run_en   <= tmu_d;
            sci_pin_rst  <= sci_rst_d;
        end
    end

endmodule

// File: rtl/pwrdn_ctrl_chk.sv
// Temporal checks for the power-down controller, bound to its top level.
// Assumes: in_hstby reflects the controller's state register.
module pwrdn_ctrl_chk (
    input logic clk,
    input logic por_n,
    input logic hwstby_n,
    input logic cpu_clk_en,
    input logic cpg_en,
    input logic mem_self_ref,
    input logic tmu_run_en,
    input logic in_hstby
);

    // R12: CPU clock never runs without the clock generator.
    assert_cpu_needs_cpg_R12: assert property (@(posedge clk) disable iff (!por_n)
        cpu_clk_en |-> cpg_en);

    // R5: the CPU clock cannot come up on the edge the clock generator does.
    assert_cpg_before_cpu_R5: assert property (@(posedge clk) disable iff (!por_n)
        !cpg_en |=> !cpu_clk_en);

    // R3: with the clock generator stopped, memory is in self-refresh.
    assert_selfref_when_stopped_R3: assert property (@(posedge clk) disable iff (!por_n)
        !cpg_en |-> mem_self_ref);

    // R8: a low pin leads to hardware standby with everything halted.
    assert_pin_enters_hstby_R8: assert property (@(posedge clk) disable iff (!por_n)
        !hwstby_n |=> (in_hstby && !cpg_en && !tmu_run_en));

    // R9: hardware standby persists until power-on reset.
    assert_hstby_sticky_R9: assert property (@(posedge clk) disable iff (!por_n)
        in_hstby |=> in_hstby);

    // R8: timer and CPU stay off in hardware standby.
    assert_hstby_quiet_R8: assert property (@(posedge clk) disable iff (!por_n)
        in_hstby |-> (!tmu_run_en && !cpu_clk_en));

endmodule

bind pwrdn_ctrl pwrdn_ctrl_chk u_chk (
    .clk          (clk),
    .por_n        (por_n),
    .hwstby_n     (hwstby_n),
    .cpu_clk_en   (cpu_clk_en),
    .cpg_en       (cpg_en),
    .mem_self_ref (mem_self_ref),
    .tmu_run_en   (tmu_run_en),
    .in_hstby     (state_q == pwrdn_pkg::PD_HSTBY)
);

// File: tb/pwrdn_ctrl_tb.sv
// Directed bench for the power-down controller.
`timescale 1ns/1ps
module pwrdn_ctrl_tb;

    localparam int NMOD = 4;

    logic            clk = 1'b0;
    logic            por_n, mrst_n, sleep_stb, stby_sel, hwstby_n, irq;
    logic            rtc_start, tmu_src_rtc;
    logic [NMOD-1:0] mod_stop;
    logic            cpu_clk_en, cpg_en, mem_self_ref, rtc_run_en, tmu_run_en, sci_pin_rst;
    logic [NMOD-1:0] mod_clk_en;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    pwrdn_ctrl #(.NMOD(NMOD)) u_dut (
        .clk(clk), .por_n(por_n), .mrst_n(mrst_n), .sleep_stb(sleep_stb),
        .stby_sel(stby_sel), .mod_stop(mod_stop), .hwstby_n(hwstby_n), .irq(irq),
        .rtc_start(rtc_start), .tmu_src_rtc(tmu_src_rtc),
        .cpu_clk_en(cpu_clk_en), .cpg_en(cpg_en), .mod_clk_en(mod_clk_en),
        .mem_self_ref(mem_self_ref), .rtc_run_en(rtc_run_en),
        .tmu_run_en(tmu_run_en), .sci_pin_rst(sci_pin_rst)
    );

    task automatic step();
        @(posedge clk);
        #2;
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Packs cpu, cpg, self_ref into 3 bits for compact comparisons.
    function automatic logic [31:0] dom();
        return {29'd0, cpu_clk_en, cpg_en, mem_self_ref};
    endfunction

    task automatic do_por();
        por_n = 1'b0;
        step();
        step();
        chk("R1 domains", dom(), 32'b110);
        chk("R1 modules", mod_clk_en, 4'hF);
        chk("R1 rtc/tmu/sci", {rtc_run_en, tmu_run_en, sci_pin_rst}, 3'b110);
        por_n = 1'b1;
        step();
    endtask

    task automatic t_sleep();
        mod_stop = 4'b0100;
        step();
        chk("R6 run gating", mod_clk_en, 4'b1011);
        sleep_stb = 1'b1; stby_sel = 1'b0;
        step();
        sleep_stb = 1'b0;
        chk("R2 sleep domains", dom(), 32'b010);
        chk("R2 sleep modules", mod_clk_en, 4'b1011);
        sleep_stb = 1'b1; stby_sel = 1'b1;
        step();
        sleep_stb = 1'b0;
        chk("R11 strobe in sleep", dom(), 32'b010);
        irq = 1'b1;
        step();
        chk("R4 irq exits sleep", dom(), 32'b110);
        step();
        chk("R11 irq in run", dom(), 32'b110);
        irq = 1'b0;
        sleep_stb = 1'b1; stby_sel = 1'b0;
        step();
        sleep_stb = 1'b0;
        mrst_n = 1'b0;
        step();
        chk("R4 mrst exits sleep", dom(), 32'b110);
        chk("R6 mrst restarts modules", mod_clk_en, 4'hF);
        mrst_n = 1'b1;
        step();
        chk("R6 stop bit after mrst", mod_clk_en, 4'b1011);
        mod_stop = 4'b0000;
        step();
    endtask

    task automatic t_stby();
        rtc_start = 1'b1; tmu_src_rtc = 1'b1;
        sleep_stb = 1'b1; stby_sel = 1'b1;
        step();
        sleep_stb = 1'b0;
        chk("R3 standby domains", dom(), 32'b001);
        chk("R3 standby modules", mod_clk_en, 4'h0);
        chk("R10 tmu from rtc", tmu_run_en, 1'b1);
        tmu_src_rtc = 1'b0;
        step();
        chk("R10 tmu other source", tmu_run_en, 1'b0);
        tmu_src_rtc = 1'b1; rtc_start = 1'b0;
        step();
        chk("R10 rtc stopped", {rtc_run_en, tmu_run_en}, 2'b00);
        rtc_start = 1'b1;
        irq = 1'b1;
        step();
        irq = 1'b0;
        chk("R5 cpg first", dom(), 32'b011);
        step();
        chk("R5 cpu second", dom(), 32'b110);
        chk("R5 modules back", mod_clk_en, 4'hF);
    endtask

    task automatic t_modstop();
        mod_stop = 4'b0011;
        step();
        chk("R6 module gating", mod_clk_en, 4'b1100);
        chk("R6 cpu unaffected", dom(), 32'b110);
        chk("R7 serial pin reset", sci_pin_rst, 1'b1);
        chk("R6 timer halted", tmu_run_en, 1'b0);
        mod_stop = 4'b0001;
        step();
        chk("R7 serial pin released", sci_pin_rst, 1'b0);
        mod_stop = 4'b0000;
        step();
        chk("R6 modules restart", mod_clk_en, 4'hF);
    endtask

    task automatic t_hw(input bit from_stby);
        sleep_stb = 1'b1; stby_sel = from_stby;
        step();
        sleep_stb = 1'b0;
        hwstby_n = 1'b0;
        step();
        chk("R8 hw standby domains", dom(), 32'b001);
        chk("R8 hw modules/tmu", {mod_clk_en, tmu_run_en}, 5'b00000);
        chk("R10 rtc in hw standby", rtc_run_en, 1'b1);
        hwstby_n = 1'b1; irq = 1'b1;
        step();
        step();
        chk("R9 irq and pin release ignored", dom(), 32'b001);
        irq = 1'b0; mrst_n = 1'b0;
        step();
        chk("R9 mrst ignored", dom(), 32'b001);
        chk("R9 modules stay off", mod_clk_en, 4'h0);
        mrst_n = 1'b1;
        do_por();
        chk("R9 por leaves hw standby", dom(), 32'b110);
    endtask

    initial begin
        por_n = 1'b0; mrst_n = 1'b1; sleep_stb = 1'b0; stby_sel = 1'b0;
        mod_stop = '0; hwstby_n = 1'b1; irq = 1'b0;
        rtc_start = 1'b1; tmu_src_rtc = 1'b0;
        do_por();
        t_sleep();
        t_stby();
        t_modstop();
        t_hw(1'b0);
        t_hw(1'b1);
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        #800000;
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

endmodule